// File: doc/BRIEF.md
# Triggered I/Q ADC Burst Capture

This block reads a fixed number of sample pairs from a two-channel parallel ADC after a trigger. The ADC puts its in-phase (I) code and its quadrature (Q) code on one shared 10-bit bus, one at a time. A rising edge on the trigger input starts a burst. The block then drives the ADC conversion clock and the channel-select line as one square wave, derived from the system clock. Both lines are high for the I half-period and low for the Q half-period. A fixed settling time after each line edge, the block latches the bus. It samples I while the lines are high and Q while they are low.

Each completed pair goes out on a buffer write port, which carries the pair index and the raw I and Q codes with a single-cycle strobe. The codes are offset binary, with mid-scale standing for zero input, and they are stored unchanged. A one-cycle done pulse marks the end of the burst. With a 200 MHz system clock, the defaults give a 2 MHz pair rate: `HALF_DIV` = 50, and `NUM_PAIRS` = 2101 pairs, which is about 1.05 ms of data.

Top module: `iq_burst_capture`

## Requirements
- R1: While reset is asserted, and whenever no burst is in progress, `adc_clk` and `adc_sel` are low and `wr_en` and `done` are low.
- R2: `adc_sel` always carries the same level as `adc_clk`.
- R3: A burst starts on a trigger edge while idle. A trigger edge is a clock edge at which `trig` is sampled high after being sampled low at the previous edge. Both lines go high in the cycle that follows that edge.
- R4: During a burst, the lines stay high for `HALF_DIV` system cycles and then low for `HALF_DIV` cycles, repeating. Each pair begins with the high half.
- R5: In each half-period, the bus is latched at the clock edge that ends the (`SETTLE`+1)-th cycle after the line change. The value on the bus at any other cycle is never stored. `SETTLE` must not exceed `HALF_DIV`-2.
- R6: For each pair, `wr_en` is high for exactly one cycle, `SETTLE`+1 cycles into the low half. At that point `wr_idx` holds the pair number, counting from 0. `wr_i` holds the code latched in the high half, and `wr_q` holds the code latched in the low half, both raw.
- R7: A burst writes exactly `NUM_PAIRS` pairs. In the cycle after the last low half ends, `done` is high for one cycle and the lines return low.
- R8: Trigger edges during a burst, including one sampled at the clock edge that ends the burst, are ignored. A trigger held high after a burst does not start another one.
- R9: A trigger edge sampled at the clock edge that ends the `done` cycle starts a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Burst trigger, rising edge active |
| adc_data | input | DATA_W | Shared ADC data bus (I or Q code) |
| adc_clk | output | 1 | ADC conversion clock |
| adc_sel | output | 1 | ADC channel select, high selects I |
| wr_en | output | 1 | Buffer write strobe, one cycle per pair |
| wr_idx | output | IDX_W | Pair index of the write |
| wr_i | output | DATA_W | Raw I code of the pair |
| wr_q | output | DATA_W | Raw Q code of the pair |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The end of one burst and the start of the next can meet at the same clock edge. A trigger edge sampled at the edge that closes the last low half must be dropped. One sampled at the next edge, while `done` is high, must start a new burst. The bench waits for `done` and raises the trigger at once, so the restart falls on the first cycle that is allowed. It also places random trigger pulses inside bursts. A cycle-count model of the expected waveform judges each case: it predicts line levels, write cycles and `done` for every cycle. In this model, a trigger edge counts only if the modelled burst was already over at that edge.

// File: rtl/iq_burst_capture.sv
module iq_burst_capture #(
  parameter int DATA_W    = 10,
  parameter int NUM_PAIRS = 2101,
  parameter int HALF_DIV  = 50,
  parameter int SETTLE    = 12,
  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_clk,
  output logic              adc_sel,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_i,
  output logic [DATA_W-1:0] wr_q,
  output logic              done
);

  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_LATCH = CNT_W'(SETTLE);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(NUM_PAIRS - 1);

  logic              trig_q;
  logic              busy;
  logic              phase;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] i_hold;

  wire trig_edge = trig & ~trig_q;
  wire at_latch  = busy && (cnt == CNT_LATCH);
  wire at_end    = busy && (cnt == CNT_LAST);

  assign adc_clk = phase;
  assign adc_sel = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      busy   <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      i_hold <= '0;
      wr_en  <= 1'b0;
      wr_idx <= '0;
      wr_i   <= '0;
      wr_q   <= '0;
      done   <= 1'b0;
    end else begin
      trig_q <= trig;
      wr_en  <= 1'b0;
      done   <= 1'b0;
      if (!busy) begin
        if (trig_edge) begin
          busy  <= 1'b1;
          phase <= 1'b1;
          cnt   <= '0;
          idx   <= '0;
        end
      end else begin
        if (at_latch) begin
          if (phase) begin
            i_hold <= adc_data;
          end else begin
            wr_en  <= 1'b1;
            wr_idx <= idx;
            wr_i   <= i_hold;
            wr_q   <= adc_data;
          end
        end
        if (at_end) begin
          cnt   <= '0;
          phase <= ~phase;
          if (!phase) begin
            if (idx == IDX_LAST) begin
              busy  <= 1'b0;
              phase <= 1'b0;
              done  <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adc_clk);

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (adc_clk && cnt == '0 && idx == '0));

  assert_toggle_at_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (adc_clk != $past(adc_clk))) |-> ($past(cnt) == CNT_LAST));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_strobe_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!adc_sel && wr_idx <= IDX_LAST));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !adc_clk));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx >= $past(idx)));

endmodule

// File: tb/iq_burst_capture_tb.sv
module iq_burst_capture_tb;
  localparam int DW = 10;
  localparam int NP = 40;
  localparam int HD = 8;
  localparam int ST = 3;
  localparam int IW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic adc_clk, adc_sel, wr_en, done;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_i, wr_q;

  always #2.5 clk = ~clk;

  iq_burst_capture #(.DATA_W(DW), .NUM_PAIRS(NP), .HALF_DIV(HD), .SETTLE(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .adc_data(adc_data),
    .adc_clk(adc_clk), .adc_sel(adc_sel), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_i(wr_i), .wr_q(wr_q), .done(done)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  bit m_busy = 1'b0;
  int t = 0;
  int wr_count = 0;
  bit trig_prev = 1'b0;
  bit restart_armed = 1'b0;
  bit first_cycle = 1'b0;
  int salt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] code(input int k, input int ch, input int s);
    return DW'((k * 97 + ch * 389 + s * 13 + 5) & ((1 << DW) - 1));
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      chk(!adc_clk && !adc_sel && !wr_en && !done, "R1 reset", int'({adc_clk, adc_sel, wr_en, done}), 0);
      trig_prev = trig;
    end else begin
      bit exp_done;
      bit exp_wr;
      bit exp_line;
      int k;
      exp_done = 1'b0;
      first_cycle = 1'b0;
      if (m_busy) begin
        t++;
        if (t == 2 * HD * NP) begin
          exp_done = 1'b1;
          m_busy = 1'b0;
        end
      end else if (trig && !trig_prev) begin
        m_busy = 1'b1;
        t = 0;
        wr_count = 0;
        first_cycle = 1'b1;
      end
      trig_prev = trig;

      exp_line = m_busy && ((t / HD) % 2 == 0);
      exp_wr = m_busy && ((t % (2 * HD)) == HD + ST + 1);
      k = t / (2 * HD);

      chk(adc_sel == adc_clk, "R2 sel equals clk", int'(adc_sel), int'(adc_clk));
      if (first_cycle && restart_armed) begin
        chk(adc_clk == 1'b1, "R9 restart at done", int'(adc_clk), 1);
        restart_armed = 1'b0;
      end else if (first_cycle) begin
        chk(adc_clk == 1'b1, "R3 start", int'(adc_clk), 1);
      end else if (m_busy) begin
        chk(adc_clk == exp_line, "R4 line level", int'(adc_clk), int'(exp_line));
      end else begin
        chk(!adc_clk && !wr_en, "R1 or R8 idle", int'({adc_clk, wr_en}), 0);
      end

      chk(wr_en == exp_wr, "R6 strobe timing", int'(wr_en), int'(exp_wr));
      if (wr_en && exp_wr) begin
        wr_count++;
        chk(int'(wr_idx) == k, "R6 index", int'(wr_idx), k);
        chk(wr_i == code(k, 0, salt), "R5 I latch", int'(wr_i), int'(code(k, 0, salt)));
        chk(wr_q == code(k, 1, salt), "R5 Q latch", int'(wr_q), int'(code(k, 1, salt)));
      end

      chk(done == exp_done, "R7 done pulse", int'(done), int'(exp_done));
      if (exp_done) begin
        chk(!adc_clk, "R7 lines low at done", int'(adc_clk), 0);
        chk(wr_count == NP, "R7 pair count", wr_count, NP);
      end

      if (m_busy && (t % (2 * HD)) == ST)
        adc_data = code(k, 0, salt);
      else if (m_busy && (t % (2 * HD)) == HD + ST)
        adc_data = code(k, 1, salt);
      else
        adc_data = code(k, (t / HD) % 2, salt) ^ DW'($urandom_range(1, (1 << DW) - 1));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    #1;
  endtask

  task automatic mid_pulses();
    for (int p = 0; p < 4; p++) begin
      step($urandom_range(10, 100));
      trig = 1'b1;
      step($urandom_range(1, 3));
      trig = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    step(5);
    rst_n = 1'b1;
    step(10);

    salt = 1;
    trig = 1'b1;
    wait_done();
    step(20);
    trig = 1'b0;
    step(5);

    salt = 2;
    trig = 1'b1;
    step(1);
    trig = 1'b0;
    mid_pulses();
    wait_done();
    restart_armed = 1'b1;
    salt = 3;
    trig = 1'b1;
    step(2);
    trig = 1'b0;
    step(2 * HD * NP - 10);
    trig = 1'b1;
    step(8);
    trig = 1'b0;
    wait_done();

    for (int b = 0; b < 3; b++) begin
      step($urandom_range(2, 30));
      salt = 10 + b;
      trig = 1'b1;
      step($urandom_range(1, 5));
      trig = 1'b0;
      mid_pulses();
      wait_done();
    end
    step(30);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule